// File: doc/BRIEF.md
# Chained-Operand Compressed Instruction Expander

This decode-stage unit takes 16-bit compressed instructions and expands each one into a full three-operand micro-operation. In the chained format, one source register is left out of the encoding. The expander fills that source with the destination register of the instruction accepted just before it. To do this, the expander tracks the most recent destination number and whether that number is still usable. Every chained micro-op carries a forwarding hint, which tells execution that the operand can come straight from the bypass latch.

The chained encoding cannot be restarted on its own, because its meaning depends on the instruction before it. The expander therefore follows three rules:
- A chained instruction reached by a control transfer is faulted.
- A chained opcode for an operation that might raise an exception is faulted.
- An interrupt is accepted only at a self-contained instruction. When the expander takes an interrupt, it consumes that instruction without emitting it, so it can be refetched after the handler.

Both edges use valid/ready. An instruction is accepted when `in_valid && in_ready`. A micro-op is delivered when `out_valid && out_ready`. The block has a single output register, so `in_ready` is high while that register is empty or being drained. While `out_valid` is high and `out_ready` is low, the micro-op stays unchanged. `flush` empties the output register and discards the chain state.

Top module: `chained_expander`

## Requirements
- R1: An instruction with bit 15 clear is a self-contained ALU op. The micro-op has kind 1, op = {0, bits 14:12}, rd = bits 11:8, rs1 = bits 7:4, rs2 = bits 3:0, write enable 1, and imm, forward hint and fault all 0.
- R2: When bit 15 is set, bits 14:12 select the format. 000 is a load: kind 2, rd = 11:8, rs1 = 7:4, imm = 3:0, write enable 1. 001 is a store: kind 3, rs1 = 11:8, rs2 = 7:4, imm = 3:0. 010 is a branch: kind 4, rs1 = 11:8, rs2 = 7:4, imm = 3:0. Stores and branches write no register. All unlisted fields are 0.
- R3: Bits 15:12 = 1111 select the chained format. If the instruction is legal, the micro-op has kind 1, op = bits 11:8, rd = bits 7:4, rs2 = bits 3:0, rs1 = the rd of the immediately preceding accepted, emitted, register-writing instruction, write enable 1 and forward hint 1.
- R4: A chained instruction accepted with `in_target` high gives a faulted micro-op: fault 1 and every other field 0.
- R5: A chained instruction whose opcode is SAFE_CHAIN_OPS (default 8) or higher gives a faulted micro-op.
- R6: A chained instruction gives a faulted micro-op if no usable destination exists. That is the case after reset, after a flush, after a taken interrupt, and after an instruction that wrote no register (store, branch or any faulted micro-op).
- R7: Prefixes 1011, 1100, 1101 and 1110 are reserved and give a faulted micro-op.
- R8: `irq_take` is high, combinationally, exactly when an instruction is accepted while `irq_req` is high and the instruction is not chained. That instruction is not emitted, and the chain state becomes unusable. When the accepted instruction is chained, `irq_req` has no effect.
- R9: A micro-op appears on the output the cycle after its instruction is accepted. `in_ready` = !flush && (!out_valid || out_ready). The output holds while it is stalled.
- R10: `flush` clears `out_valid` on the next cycle and blocks acceptance while it is high.
- R11: During and after reset, `out_valid` is 0 and the chain state is unusable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the pending micro-op and the chain state |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted |
| in_instr | input | 16 | Compressed instruction |
| in_target | input | 1 | Instruction is the destination of a control transfer |
| irq_req | input | 1 | Interrupt pending |
| irq_take | output | 1 | Interrupt accepted at this instruction |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer accepts the micro-op |
| out_kind | output | 3 | 0 none, 1 ALU, 2 load, 3 store, 4 branch |
| out_op | output | 4 | ALU operation |
| out_rd | output | 4 | Destination register |
| out_rs1 | output | 4 | First source (the inferred one when chained) |
| out_rs2 | output | 4 | Second source |
| out_imm | output | 4 | Immediate |
| out_wr_en | output | 1 | Micro-op writes rd |
| out_fwd | output | 1 | Take rs1 from the forwarding latch |
| out_fault | output | 1 | Illegal-instruction fault |

## Verification
The bench targets the cases where the inferred source could be stale:
- A chained instruction after a store, branch, fault, flush or taken interrupt must fault. A design that keeps the old destination would instead emit a forwarded micro-op with the wrong rs1.
- A chained instruction that follows another chained one must take the newer rd.

It also checks:
- An interrupt raised under a chained instruction. A design that ignores the boundary rule would pulse `irq_take` and lose that instruction.
- A chained instruction at a branch target, and unsafe chained opcodes. A design that got these wrong would pass them through as legal work.
- Long output stalls. A design that got these wrong would overwrite or duplicate micro-ops.

// File: rtl/chx_pkg.sv
package chx_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_W   = 4;
  localparam int OP_W    = 4;
  localparam int IMM_W   = 4;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_ALU    = 3'd1,
    K_LOAD   = 3'd2,
    K_STORE  = 3'd3,
    K_BRANCH = 3'd4
  } kind_t;

  typedef struct packed {
    kind_t              kind;
    logic [OP_W-1:0]    op;
    logic [REG_W-1:0]   rd;
    logic [REG_W-1:0]   rs1;
    logic [REG_W-1:0]   rs2;
    logic [IMM_W-1:0]   imm;
    logic               wr_en;
    logic               fwd;
    logic               fault;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);

  // format selector in bits 14:12 when bit 15 is set
  localparam logic [2:0] PFX_LOAD   = 3'b000;
  localparam logic [2:0] PFX_STORE  = 3'b001;
  localparam logic [2:0] PFX_BRANCH = 3'b010;
  localparam logic [2:0] PFX_CHAIN  = 3'b111;
endpackage

// File: rtl/chx_decode.sv
module chx_decode
  import chx_pkg::*;
#(
  parameter int SAFE_CHAIN_OPS = 8
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               at_target,
  input  logic               chain_ok,
  input  logic [REG_W-1:0]   chain_rd,
  output uop_t               uop,
  output logic               is_chain
);
  localparam logic [OP_W:0] SAFE_LIM = (OP_W+1)'(SAFE_CHAIN_OPS);

  logic [2:0] pfx;
  logic       op_safe;
  logic       chain_legal;

  assign pfx         = instr[14:12];
  assign is_chain    = instr[15] && (pfx == PFX_CHAIN);
  assign op_safe     = ({1'b0, instr[11:8]} < SAFE_LIM);
  assign chain_legal = op_safe && chain_ok && !at_target;

  always_comb begin
    uop = '0;
    if (!instr[15]) begin
      uop.kind  = K_ALU;
      uop.op    = {1'b0, instr[14:12]};
      uop.rd    = instr[11:8];
      uop.rs1   = instr[7:4];
      uop.rs2   = instr[3:0];
      uop.wr_en = 1'b1;
    end else begin
      case (pfx)
        PFX_CHAIN: begin
          if (chain_legal) begin
            uop.kind  = K_ALU;
            uop.op    = instr[11:8];
            uop.rd    = instr[7:4];
            uop.rs1   = chain_rd;
            uop.rs2   = instr[3:0];
            uop.wr_en = 1'b1;
            uop.fwd   = 1'b1;
          end else begin
            uop.fault = 1'b1;
          end
        end
        PFX_LOAD: begin
          uop.kind  = K_LOAD;
          uop.rd    = instr[11:8];
          uop.rs1   = instr[7:4];
          uop.imm   = instr[3:0];
          uop.wr_en = 1'b1;
        end
        PFX_STORE: begin
          uop.kind = K_STORE;
          uop.rs1  = instr[11:8];
          uop.rs2  = instr[7:4];
          uop.imm  = instr[3:0];
        end
        PFX_BRANCH: begin
          uop.kind = K_BRANCH;
          uop.rs1  = instr[11:8];
          uop.rs2  = instr[7:4];
          uop.imm  = instr[3:0];
        end
        default: uop.fault = 1'b1;  // reserved prefixes, R7
      endcase
    end
  end

  always_comb begin
    if (uop.fwd) a_fwd_legal_r3: assert (is_chain && !at_target && chain_ok);
  end
endmodule

// File: rtl/chx_chain_track.sv
module chx_chain_track
  import chx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             take,
  input  logic             push,
  input  logic             wr_en,
  input  logic [REG_W-1:0] rd,
  output logic             chain_ok,
  output logic [REG_W-1:0] chain_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_ok <= 1'b0;
      chain_rd <= '0;
    end else if (flush || take) begin
      chain_ok <= 1'b0;
    end else if (push) begin
      chain_ok <= wr_en;
      if (wr_en) chain_rd <= rd;
    end
  end

  p_nowrite_breaks_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !wr_en) |=> !chain_ok);

  p_take_breaks_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !chain_ok);

  p_write_records_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && wr_en && !flush && !take) |=> (chain_ok && chain_rd == $past(rd)));
endmodule

// File: rtl/chx_out_stage.sv
module chx_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] d,
  output logic         in_ready,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] q
);
  assign in_ready = !flush && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));

  p_push_has_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> in_ready);

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/chained_expander.sv
module chained_expander
  import chx_pkg::*;
#(
  parameter int SAFE_CHAIN_OPS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_instr,
  input  logic        in_target,
  input  logic        irq_req,
  output logic        irq_take,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [2:0]  out_kind,
  output logic [3:0]  out_op,
  output logic [3:0]  out_rd,
  output logic [3:0]  out_rs1,
  output logic [3:0]  out_rs2,
  output logic [3:0]  out_imm,
  output logic        out_wr_en,
  output logic        out_fwd,
  output logic        out_fault
);
  localparam logic [OP_W:0] UNSAFE_FROM = (OP_W+1)'(SAFE_CHAIN_OPS);

  uop_t             dec_uop;
  uop_t             q_uop;
  logic [UOP_W-1:0] q_bits;
  logic             is_chain;
  logic             chain_ok;
  logic [REG_W-1:0] chain_rd;
  logic             accept;
  logic             push;

  assign accept   = in_valid && in_ready;
  assign irq_take = accept && irq_req && !is_chain;
  assign push     = accept && !irq_take;

  chx_decode #(.SAFE_CHAIN_OPS(SAFE_CHAIN_OPS)) u_decode (
    .instr     (in_instr),
    .at_target (in_target),
    .chain_ok  (chain_ok),
    .chain_rd  (chain_rd),
    .uop       (dec_uop),
    .is_chain  (is_chain)
  );

  chx_chain_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .take     (irq_take),
    .push     (push),
    .wr_en    (dec_uop.wr_en),
    .rd       (dec_uop.rd),
    .chain_ok (chain_ok),
    .chain_rd (chain_rd)
  );

  chx_out_stage #(.W(UOP_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .d         (dec_uop),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .q         (q_bits)
  );

  assign q_uop     = uop_t'(q_bits);
  assign out_kind  = q_uop.kind;
  assign out_op    = q_uop.op;
  assign out_rd    = q_uop.rd;
  assign out_rs1   = q_uop.rs1;
  assign out_rs2   = q_uop.rs2;
  assign out_imm   = q_uop.imm;
  assign out_wr_en = q_uop.wr_en;
  assign out_fwd   = q_uop.fwd;
  assign out_fault = q_uop.fault;

  p_target_chain_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_chain && in_target) |=> (out_valid && out_fault && !out_fwd));

  p_unsafe_chain_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_chain && ({1'b0, in_instr[11:8]} >= UNSAFE_FROM)) |=> (out_valid && out_fault));

  p_take_emits_nothing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !out_valid);

  p_reset_empty_r11: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/chained_expander_bench.sv
module chained_expander_bench;
  import chx_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic in_valid = 1'b0, in_target = 1'b0, irq_req = 1'b0, out_ready = 1'b0;
  logic [15:0] in_instr = '0;
  logic in_ready, irq_take, out_valid, out_wr_en, out_fwd, out_fault;
  logic [2:0] out_kind;
  logic [3:0] out_op, out_rd, out_rs1, out_rs2, out_imm;

  int total = 0, failed = 0;
  logic   m_valid = 1'b0, m_lv = 1'b0;
  logic [3:0] m_lr = '0;
  uop_t   m_uop = '0;
  string  m_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  chained_expander u_chained_expander (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_target(in_target), .irq_req(irq_req), .irq_take(irq_take),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_op(out_op),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_imm(out_imm),
    .out_wr_en(out_wr_en), .out_fwd(out_fwd), .out_fault(out_fault)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic uop_t model(input logic [15:0] i, input logic tgt,
                                 input logic lv, input logic [3:0] lr, output string tag);
    uop_t u = '0;
    tag = "R1";
    if (!i[15]) begin
      u.kind = K_ALU; u.op = {1'b0, i[14:12]}; u.rd = i[11:8]; u.rs1 = i[7:4];
      u.rs2 = i[3:0]; u.wr_en = 1'b1;
    end else if (i[14:12] == 3'b111) begin
      if (tgt) begin u.fault = 1'b1; tag = "R4"; end
      else if (i[11:8] >= 4'd8) begin u.fault = 1'b1; tag = "R5"; end
      else if (!lv) begin u.fault = 1'b1; tag = "R6"; end
      else begin
        tag = "R3"; u.kind = K_ALU; u.op = i[11:8]; u.rd = i[7:4]; u.rs1 = lr;
        u.rs2 = i[3:0]; u.wr_en = 1'b1; u.fwd = 1'b1;
      end
    end else if (i[14:12] == 3'b000) begin
      tag = "R2"; u.kind = K_LOAD; u.rd = i[11:8]; u.rs1 = i[7:4]; u.imm = i[3:0]; u.wr_en = 1'b1;
    end else if (i[14:12] == 3'b001) begin
      tag = "R2"; u.kind = K_STORE; u.rs1 = i[11:8]; u.rs2 = i[7:4]; u.imm = i[3:0];
    end else if (i[14:12] == 3'b010) begin
      tag = "R2"; u.kind = K_BRANCH; u.rs1 = i[11:8]; u.rs2 = i[7:4]; u.imm = i[3:0];
    end else begin
      tag = "R7"; u.fault = 1'b1;
    end
    return u;
  endfunction

  // one cycle: check outputs, drive inputs, check combinational outputs, advance model
  task automatic step(input logic v, input logic [15:0] ins, input logic tgt,
                      input logic irq, input logic ordy, input logic fl);
    uop_t act, nu;
    string tag;
    logic acc, exp_rdy, exp_take, is_ch;
    act.kind = kind_t'(out_kind); act.op = out_op; act.rd = out_rd; act.rs1 = out_rs1;
    act.rs2 = out_rs2; act.imm = out_imm; act.wr_en = out_wr_en; act.fwd = out_fwd;
    act.fault = out_fault;
    chk(out_valid == m_valid, "R9", "out_valid", 64'(out_valid), 64'(m_valid));
    if (m_valid && out_valid) chk(act == m_uop, m_tag, "uop", 64'(act), 64'(m_uop));
    in_valid = v; in_instr = ins; in_target = tgt; irq_req = irq; out_ready = ordy; flush = fl;
    #1;
    is_ch    = (ins[15:12] == 4'hF);
    exp_rdy  = !fl && (!m_valid || ordy);
    acc      = v && exp_rdy;
    exp_take = acc && irq && !is_ch;
    chk(in_ready == exp_rdy, fl ? "R10" : "R9", "in_ready", 64'(in_ready), 64'(exp_rdy));
    chk(irq_take == exp_take, "R8", "irq_take", 64'(irq_take), 64'(exp_take));
    nu = model(ins, tgt, m_lv, m_lr, tag);
    if (fl) begin
      m_valid = 1'b0; m_lv = 1'b0;
    end else begin
      if (m_valid && ordy) m_valid = 1'b0;
      if (exp_take) m_lv = 1'b0;
      else if (acc) begin
        m_valid = 1'b1; m_uop = nu; m_tag = tag;
        m_lv = nu.wr_en;
        if (nu.wr_en) m_lr = nu.rd;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] rand_instr();
    int r = $urandom % 10;
    logic [15:0] x = 16'($urandom);
    case (r)
      0, 1, 2, 3: return {4'hF, ($urandom % 5 == 0) ? x[11:8] : {1'b0, x[10:8]}, x[7:0]};
      4, 5:       return {1'b0, x[14:0]};
      6:          return {4'h8, x[11:0]};
      7:          return {4'h9, x[11:0]};
      8:          return {4'hA, x[11:0]};
      default:    return {1'b1, 3'(3 + $urandom % 4), x[11:0]};
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6/R11: chained straight after reset faults
    step(1, 16'hF123, 0, 0, 1, 0);
    // R1 then R3: chain from r5, then chain from chained rd 7
    step(1, 16'h2512, 0, 0, 1, 0);
    step(1, 16'hF379, 0, 0, 1, 0);
    step(1, 16'hF1A4, 0, 0, 1, 0);
    // R4: chained at branch target
    step(1, 16'hF234, 1, 0, 1, 0);
    // R5: unsafe opcode
    step(1, 16'h0345, 0, 0, 1, 0);
    step(1, 16'hF934, 0, 0, 1, 0);
    // R6: store then chained
    step(1, 16'h0345, 0, 0, 1, 0);
    step(1, 16'h9321, 0, 0, 1, 0);
    step(1, 16'hF234, 0, 0, 1, 0);
    // R8: interrupt under chained is held off, then taken at self-contained
    step(1, 16'h1456, 0, 0, 1, 0);
    step(1, 16'hF2B1, 0, 1, 1, 0);
    step(1, 16'h3C01, 0, 1, 1, 0);
    step(1, 16'hF2C1, 0, 0, 1, 0);
    // R7 reserved, R2 load, R9 stall with hold
    step(1, 16'hC000, 0, 0, 1, 0);
    step(1, 16'h8E3F, 0, 0, 0, 0);
    step(1, 16'h0111, 0, 0, 0, 0);
    step(0, 16'h0000, 0, 0, 0, 0);
    step(0, 16'h0000, 0, 0, 1, 0);
    // R10: flush drops pending and chain
    step(1, 16'h0222, 0, 0, 0, 0);
    step(1, 16'h0333, 0, 0, 0, 1);
    step(1, 16'hF111, 0, 0, 1, 0);
    step(0, 16'h0000, 0, 0, 1, 0);
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 5) != 0, rand_instr(), ($urandom % 8) == 0, ($urandom % 6) == 0,
           ($urandom % 4) != 0, ($urandom % 40) == 0);
    end
    step(0, 16'h0000, 0, 0, 1, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule